// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit decides where a 32-bit base-integer processor fetches next after one instruction. From the instruction word, the current program counter and the two source operand values, it works out three things. The first is whether control flow is redirected and to which address. The second is whether a return address has to be written back, and its value. The third is whether the chosen target breaks the instruction alignment rule or the branch condition code is not defined.

It handles conditional branches, direct jumps with link and register-indirect jumps with link. The offsets of the first two are spread across the instruction word, and the unit gathers them back into signed byte offsets. Every other instruction simply advances the program counter by four. Fetch, pipeline flushing and trap delivery are left to the surrounding core, which consumes the flags.

Top module: `brjmp_nextpc`

## Requirements
- R1: An instruction whose low seven bits are not 1100011, 1101111 or 1100111 gives next_pc = pc + 4, with taken, link_we, misalign and illegal all 0.
- R2: Opcode 1100011 is a conditional branch whose condition is chosen by bits 14:12: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. When the condition holds, taken is 1.
- R3: The offset of a taken branch is a sign-extended 13-bit value. Instruction bit 31 supplies offset bit 12, bit 7 supplies bit 11, bits 30:25 supply bits 10:5 and bits 11:8 supply bits 4:1, and offset bit 0 is zero. next_pc is pc plus this offset.
- R4: A branch whose condition fails gives next_pc = pc + 4 and taken 0.
- R5: Opcode 1101111 always jumps. Its 21-bit offset takes bit 20 from instruction bit 31, bits 19:12 from bits 19:12, bit 11 from bit 20 and bits 10:1 from bits 30:21, with bit 0 zero. next_pc is pc plus the sign-extended offset, and link_data is pc + 4.
- R6: Opcode 1100111 always jumps to src_a plus the sign-extended bits 31:20, with bit 0 of the sum cleared, and link_data is pc + 4.
- R7: link_we is 1 only for the two jump opcodes, and only when the destination field (bits 11:7) is not zero.
- R8: misalign is 1 exactly when the unit redirects (taken 1) and the target has any of its low ALIGN_LOG2 bits set. A branch that is not taken never raises it.
- R9: A branch with condition code 010 or 011 raises illegal, is not taken and gives next_pc = pc + 4.
- R10: All address sums wrap modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| src_a_i | input | XLEN | First source operand (branch left side, indirect base) |
| src_b_i | input | XLEN | Second source operand (branch right side) |
| next_pc_o | output | XLEN | Address to fetch next |
| taken_o | output | 1 | Control flow is redirected |
| link_we_o | output | 1 | Write link_data_o to the destination register |
| link_data_o | output | XLEN | Return address, pc + 4 |
| misalign_o | output | 1 | Redirect target violates alignment |
| illegal_o | output | 1 | Undefined branch condition code |

## Verification
The bench builds two copies of the unit, both with XLEN 32. The first uses ALIGN_LOG2 2, where only word-aligned targets are legal, so a branch or indirect jump landing at an address with bit 1 set must raise the alignment flag. The second uses ALIGN_LOG2 1, which stands for two-byte alignment. It runs the same targets and shows that the flag depends on the parameter, and that the cleared bit 0 of an indirect jump never sets it. Wrap-around cases at the top of the 32-bit address space exercise the modulo arithmetic at the default width.

// File: rtl/brjmp_pkg.sv
package brjmp_pkg;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    typedef enum logic [1:0] {
        CF_NONE   = 2'd0,
        CF_BRANCH = 2'd1,
        CF_JAL    = 2'd2,
        CF_JALR   = 2'd3
    } cf_kind_e;

    typedef enum logic [2:0] {
        COND_EQ  = 3'b000,
        COND_NE  = 3'b001,
        COND_LT  = 3'b100,
        COND_GE  = 3'b101,
        COND_LTU = 3'b110,
        COND_GEU = 3'b111
    } cond_e;

    typedef struct packed {
        cf_kind_e    kind;
        logic [2:0]  cond;
        logic [4:0]  rd;
        logic [31:0] offset;
    } cf_ctrl_t;

    // Conditional-branch offset, sign-extended to 32 bits
    function automatic logic [31:0] imm_branch(input logic [31:0] w);
        return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    // Direct-jump offset, sign-extended to 32 bits
    function automatic logic [31:0] imm_jump(input logic [31:0] w);
        return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
    endfunction

    // Indirect-jump 12-bit immediate, sign-extended to 32 bits
    function automatic logic [31:0] imm_indirect(input logic [31:0] w);
        return {{20{w[31]}}, w[31:20]};
    endfunction

endpackage

// File: rtl/brjmp_decode.sv
module brjmp_decode
    import brjmp_pkg::*;
(
    input  logic [31:0] instr,
    output cf_ctrl_t    ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.cond   = instr[14:12];
        ctrl.rd     = instr[11:7];
        case (instr[6:0])
            OPC_BRANCH: begin
                ctrl.kind   = CF_BRANCH;
                ctrl.offset = imm_branch(instr);
            end
            OPC_JAL: begin
                ctrl.kind   = CF_JAL;
                ctrl.offset = imm_jump(instr);
            end
            OPC_JALR: begin
                ctrl.kind   = CF_JALR;
                ctrl.offset = imm_indirect(instr);
            end
            default: begin
                ctrl.kind   = CF_NONE;
                ctrl.offset = '0;
            end
        endcase
    end

endmodule

// File: rtl/brjmp_cmp.sv
module brjmp_cmp
    import brjmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [2:0]      cond,
    output logic            hit,
    output logic            bad
);

    logic same;
    logic less_s;
    logic less_u;

    assign same   = (a == b);
    assign less_s = ($signed(a) < $signed(b));
    assign less_u = (a < b);

    always_comb begin
        hit = 1'b0;
        bad = 1'b0;
        case (cond)
            COND_EQ:  hit = same;
            COND_NE:  hit = !same;
            COND_LT:  hit = less_s;
            COND_GE:  hit = !less_s;
            COND_LTU: hit = less_u;
            COND_GEU: hit = !less_u;
            default:  bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/brjmp_target.sv
module brjmp_target
    import brjmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] base_reg,
    input  cf_kind_e        kind,
    input  logic [31:0]     offset,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] tgt_pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] off_x;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] sum;

    assign off_x  = XLEN'($signed(offset));
    assign seq_pc = pc + STEP;
    assign base   = (kind == CF_JALR) ? base_reg : pc;
    assign sum    = base + off_x;
    assign tgt_pc = (kind == CF_JALR) ? {sum[XLEN-1:1], 1'b0} : sum;

endmodule

// File: rtl/brjmp_nextpc.sv
module brjmp_nextpc
    import brjmp_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ALIGN_LOG2 = 2
) (
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            taken_o,
    output logic            link_we_o,
    output logic [XLEN-1:0] link_data_o,
    output logic            misalign_o,
    output logic            illegal_o
);

    cf_ctrl_t        ctrl;
    logic            cond_hit;
    logic            cond_bad;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] tgt_pc;
    logic            is_jump;
    logic            redirect;

    brjmp_decode u_decode (
        .instr (instr_i),
        .ctrl  (ctrl)
    );

    brjmp_cmp #(.XLEN(XLEN)) u_cmp (
        .a    (src_a_i),
        .b    (src_b_i),
        .cond (ctrl.cond),
        .hit  (cond_hit),
        .bad  (cond_bad)
    );

    brjmp_target #(.XLEN(XLEN)) u_target (
        .pc       (pc_i),
        .base_reg (src_a_i),
        .kind     (ctrl.kind),
        .offset   (ctrl.offset),
        .seq_pc   (seq_pc),
        .tgt_pc   (tgt_pc)
    );

    assign is_jump     = (ctrl.kind == CF_JAL) || (ctrl.kind == CF_JALR);
    assign redirect    = is_jump || ((ctrl.kind == CF_BRANCH) && cond_hit);
    assign taken_o     = redirect;
    assign next_pc_o   = redirect ? tgt_pc : seq_pc;
    assign link_we_o   = is_jump && (ctrl.rd != 5'd0);
    assign link_data_o = seq_pc;
    assign illegal_o   = (ctrl.kind == CF_BRANCH) && cond_bad;

    generate
        if (ALIGN_LOG2 > 0) begin : g_align_chk
            assign misalign_o = redirect && (|tgt_pc[ALIGN_LOG2-1:0]);
        end else begin : g_no_align_chk
            assign misalign_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/brjmp_nextpc_chk.sv
module brjmp_nextpc_chk #(
    parameter int XLEN       = 32,
    parameter int ALIGN_LOG2 = 2
) (
    input logic [31:0]     instr_i,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] src_a_i,
    input logic [XLEN-1:0] src_b_i,
    input logic [XLEN-1:0] next_pc_o,
    input logic            taken_o,
    input logic            link_we_o,
    input logic            misalign_o,
    input logic            illegal_o
);

    logic is_br;
    logic is_jmp;
    logic is_ind;

    assign is_br  = (instr_i[6:0] == 7'b1100011);
    assign is_jmp = (instr_i[6:0] == 7'b1101111) || (instr_i[6:0] == 7'b1100111);
    assign is_ind = (instr_i[6:0] == 7'b1100111);

    always_comb begin
        if (!is_br && !is_jmp) begin
            // R1
            plain_step_chk: assert (!taken_o && !link_we_o && !illegal_o
                                    && next_pc_o == pc_i + XLEN'(4));
        end
        if (is_br && instr_i[14:12] == 3'b000 && src_a_i == src_b_i) begin
            // R2
            eq_taken_chk: assert (taken_o);
        end
        if (is_br && !taken_o) begin
            // R4
            fallthrough_chk: assert (next_pc_o == pc_i + XLEN'(4));
        end
        if (is_ind) begin
            // R6
            ind_bit0_chk: assert (taken_o && !next_pc_o[0]);
        end
        if (link_we_o) begin
            // R7
            link_rd_chk: assert (is_jmp && instr_i[11:7] != 5'd0);
        end
        if (misalign_o) begin
            // R8
            misalign_taken_chk: assert (taken_o);
        end
        if (illegal_o) begin
            // R9
            illegal_not_taken_chk: assert (is_br && !taken_o);
        end
    end

endmodule

bind brjmp_nextpc brjmp_nextpc_chk #(
    .XLEN       (XLEN),
    .ALIGN_LOG2 (ALIGN_LOG2)
) u_chk (
    .instr_i    (instr_i),
    .pc_i       (pc_i),
    .src_a_i    (src_a_i),
    .src_b_i    (src_b_i),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o),
    .link_we_o  (link_we_o),
    .misalign_o (misalign_o),
    .illegal_o  (illegal_o)
);

// File: tb/tb_brjmp_nextpc.sv
`timescale 1ns/1ps
module tb_brjmp_nextpc;

    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [31:0] pc;
    logic [31:0] sa;
    logic [31:0] sb;

    logic [31:0] nxt, nxt2, ldat, ldat2;
    logic        tkn, tkn2, lwe, lwe2, mis, mis2, ill, ill2;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    brjmp_nextpc #(.XLEN(32), .ALIGN_LOG2(2)) dut (
        .instr_i(instr), .pc_i(pc), .src_a_i(sa), .src_b_i(sb),
        .next_pc_o(nxt), .taken_o(tkn), .link_we_o(lwe),
        .link_data_o(ldat), .misalign_o(mis), .illegal_o(ill));

    brjmp_nextpc #(.XLEN(32), .ALIGN_LOG2(1)) dut_half (
        .instr_i(instr), .pc_i(pc), .src_a_i(sa), .src_b_i(sb),
        .next_pc_o(nxt2), .taken_o(tkn2), .link_we_o(lwe2),
        .link_data_o(ldat2), .misalign_o(mis2), .illegal_o(ill2));

    function automatic logic [31:0] enc_br(input logic [2:0] f3, input logic [12:0] off);
        return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_jal(input logic [4:0] rd, input logic [20:0] off);
        return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_jalr(input logic [4:0] rd, input logic [11:0] imm);
        return {imm, 5'd1, 3'b000, rd, 7'b1100111};
    endfunction

    function automatic bit cond_ref(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
        case (f3)
            3'b000:  return a == b;
            3'b001:  return a != b;
            3'b100:  return $signed(a) < $signed(b);
            3'b101:  return $signed(a) >= $signed(b);
            3'b110:  return a < b;
            3'b111:  return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [31:0] p,
                         input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        instr = i; pc = p; sa = a; sb = b;
        #1;
    endtask

    task automatic t_plain();
        apply(32'h00500093, 32'h0000_0100, 32'h55, 32'h55);
        chk("R1 next_pc", nxt, 32'h104);
        chk("R1 taken", {31'd0, tkn}, 0);
        chk("R1 link_we", {31'd0, lwe}, 0);
        chk("R1 misalign", {31'd0, mis}, 0);
        chk("R1 illegal", {31'd0, ill}, 0);
    endtask

    task automatic t_conds();
        logic [31:0] av [4] = '{32'd5, 32'hFFFF_FFFF, 32'd1, 32'h8000_0000};
        logic [31:0] bv [4] = '{32'd5, 32'd1, 32'hFFFF_FFFF, 32'd7};
        logic [2:0]  fs [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 6; f++) begin
                bit e;
                e = cond_ref(fs[f], av[p], bv[p]);
                apply(enc_br(fs[f], 13'd64), 32'h2000, av[p], bv[p]);
                // R2 condition, R4 fall-through
                chk($sformatf("R2 taken f3=%b p=%0d", fs[f], p), {31'd0, tkn}, {31'd0, e});
                chk($sformatf("R4 next_pc f3=%b p=%0d", fs[f], p), nxt,
                    e ? 32'h2040 : 32'h2004);
            end
        end
    endtask

    task automatic t_br_offsets();
        apply(enc_br(3'b000, 13'h1FF8), 32'h1000, 1, 1);
        chk("R3 negative offset", nxt, 32'h0FF8);
        apply(enc_br(3'b000, 13'h0FFC), 32'h1000, 1, 1);
        chk("R3 max positive offset", nxt, 32'h1FFC);
        apply(enc_br(3'b001, 13'h1000), 32'h3000, 1, 2);
        chk("R3 min offset", nxt, 32'h2000);
        apply(enc_br(3'b001, 13'h0A54), 32'h4000, 1, 2);
        chk("R3 mixed bits", nxt, 32'h4A54);
        chk("R3 no link", {31'd0, lwe}, 0);
    endtask

    task automatic t_jal();
        apply(enc_jal(5'd1, 21'h0ABCD4), 32'h0001_0000, 0, 0);
        chk("R5 target", nxt, 32'h000B_BCD4);
        chk("R5 taken", {31'd0, tkn}, 1);
        chk("R5 link_data", ldat, 32'h0001_0004);
        chk("R5 link_we", {31'd0, lwe}, 1);
        apply(enc_jal(5'd5, 21'h100000), 32'h0020_0000, 0, 0);
        chk("R5 min offset", nxt, 32'h0010_0000);
    endtask

    task automatic t_jalr();
        apply(enc_jalr(5'd1, 12'd5), 32'h0000_0800, 32'h2003, 0);
        chk("R6 target bit0 cleared", nxt, 32'h2008);
        chk("R6 link_data", ldat, 32'h0804);
        chk("R6 link_we", {31'd0, lwe}, 1);
        apply(enc_jalr(5'd3, 12'h800), 32'h0, 32'h0001_0000, 0);
        chk("R6 negative imm", nxt, 32'h0000_F800);
    endtask

    task automatic t_link_zero();
        apply(enc_jal(5'd0, 21'h40), 32'h100, 0, 0);
        chk("R7 rd0 link_we", {31'd0, lwe}, 0);
        chk("R7 rd0 still taken", nxt, 32'h140);
        apply(enc_jalr(5'd0, 12'd0), 32'h100, 32'h300, 0);
        chk("R7 rd0 indirect link_we", {31'd0, lwe}, 0);
    endtask

    task automatic t_misalign();
        apply(enc_br(3'b000, 13'd6), 32'h1000, 3, 3);
        chk("R8 taken bit1 target", {31'd0, mis}, 1);
        chk("R8 two-byte variant", {31'd0, mis2}, 0);
        apply(enc_br(3'b001, 13'd6), 32'h1000, 3, 3);
        chk("R8 not taken no flag", {31'd0, mis}, 0);
        apply(enc_jalr(5'd1, 12'hFFF), 32'h0, 32'h10, 0);
        chk("R8 indirect target", nxt, 32'h0E);
        chk("R8 indirect misalign", {31'd0, mis}, 1);
        chk("R8 indirect two-byte", {31'd0, mis2}, 0);
        apply(enc_jal(5'd1, 21'h10), 32'h100, 0, 0);
        chk("R8 aligned jump", {31'd0, mis}, 0);
    endtask

    task automatic t_illegal();
        for (int k = 2; k < 4; k++) begin
            apply(enc_br(3'(k), 13'd32), 32'h500, 9, 9);
            chk($sformatf("R9 illegal f3=%0d", k), {31'd0, ill}, 1);
            chk($sformatf("R9 not taken f3=%0d", k), {31'd0, tkn}, 0);
            chk($sformatf("R9 next_pc f3=%0d", k), nxt, 32'h504);
        end
        apply(enc_br(3'b000, 13'd32), 32'h500, 9, 9);
        chk("R9 legal code clear", {31'd0, ill}, 0);
    endtask

    task automatic t_wrap();
        apply(32'h0000_0013, 32'hFFFF_FFFC, 0, 0);
        chk("R10 sequential wrap", nxt, 32'h0);
        apply(enc_jal(5'd1, 21'h20), 32'hFFFF_FFF0, 0, 0);
        chk("R10 jump wrap", nxt, 32'h10);
        apply(enc_br(3'b000, 13'h1FF0), 32'h4, 0, 0);
        chk("R10 backward wrap", nxt, 32'hFFFF_FFF4);
    endtask

    initial begin
        instr = 32'h0; pc = 32'h0; sa = 32'h0; sb = 32'h0;
        t_plain();
        t_conds();
        t_br_offsets();
        t_jal();
        t_jalr();
        t_link_zero();
        t_misalign();
        t_illegal();
        t_wrap();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule